// File: doc/BRIEF.md
# Multi-Channel Trigger Combiner

This block decides when a waveform-capture board stops sampling. Eight comparator hit lines arrive asynchronously, one per analog channel. Each line is synchronized and edge-detected, then gated by a per-channel enable mask. The surviving hit edges are merged by a coincidence function that is either AND or OR. A board configured as a chain follower can also fire from an external trigger line that comes from the board before it.

When the block fires it raises a held trigger level that stops local sampling. It snapshots which enabled channels were high and emits a pulse of fixed length toward the next board in the chain. It then ignores every further trigger source until a re-arm strobe returns it to the armed state.

Top module: `trig_combiner`

## Requirements
- R1: While reset is asserted and after it is released, `trig`, `trig_out` and `hit_pattern` are all zero until a trigger fires.
- R2: In OR mode (`and_mode`=0), a rising edge on any enabled hit input fires the trigger. `trig` goes high on the third rising clock edge after the input changes, counting two synchronizer stages and the trigger register.
- R3: A channel whose bit in `chan_en` is 0 cannot fire the trigger in either mode.
- R4: Each firing produces exactly `PULSE_CYCLES` consecutive high cycles on `trig_out`, which default to 8 and start in the same cycle that `trig` rises.
- R5: `hit_pattern` bit i is set when channel i was enabled and its synchronized hit was high in the firing cycle. The value holds unchanged until the next firing.
- R6: After firing, `trig` stays high, and all hit and external edges are ignored (no new pulse, no pattern change) until `rearm` is sampled high.
- R7: `rearm` sampled high while fired clears `trig` on that clock edge, and the block is armed again.
- R8: In AND mode (`and_mode`=1), the trigger fires only when every enabled channel shows a rising edge in the same cycle; masked channels count as true. With all channels masked it never fires from hits.
- R9: With `follower`=1, a rising edge on `ext_trig` fires the trigger with the same latency as a hit. With `follower`=0, `ext_trig` has no effect.
- R10: Triggers are edge-sensitive: a hit held high across a re-arm does not fire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | 8 | Asynchronous comparator hits, one per channel |
| ext_trig | input | 1 | Asynchronous trigger from the preceding board |
| chan_en | input | 8 | Per-channel enable mask (1 = channel takes part) |
| and_mode | input | 1 | 1 = AND coincidence, 0 = OR |
| follower | input | 1 | 1 = accept `ext_trig` |
| rearm | input | 1 | Return from fired to armed |
| trig | output | 1 | Held acquisition-stop trigger |
| trig_out | output | 1 | Fixed-width pulse to the next board |
| hit_pattern | output | 8 | Enabled channels high at the moment of firing |

## Verification
The assertions check on every cycle the properties that do not depend on the input pattern. The chain pulse may only start together with a new trigger, and it must last exactly the configured length. The trigger must hold until re-armed, the latched pattern must not move while fired, and the pattern must never show a masked channel. The coincidence rules need the bench's scenarios: OR versus AND, masked-as-true, all-masked, and follower versus chain-head handling of the external line. So do the three-cycle firing latency and the edge-only behaviour across a re-arm.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic {ST_ARMED = 1'b0, ST_FIRED = 1'b1} trig_state_e;
endpackage

// File: rtl/trig_sync_edge.sv
// Two-stage synchronizer plus rising-edge detector, W bits wide.
module trig_sync_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
endmodule

// File: rtl/trig_coinc.sv
// Masked AND/OR coincidence of per-channel edge strobes.
module trig_coinc #(
  parameter int N_CH = 8
) (
  input  logic [N_CH-1:0] edge_in,
  input  logic [N_CH-1:0] chan_en,
  input  logic            and_mode,
  output logic            hit_fire
);
  logic [N_CH-1:0] and_terms;
  logic [N_CH-1:0] or_terms;

  genvar g;
  generate
    for (g = 0; g < N_CH; g++) begin : g_term
      assign and_terms[g] = edge_in[g] | ~chan_en[g];
      assign or_terms[g]  = edge_in[g] &  chan_en[g];
    end
  endgenerate

  always_comb begin
    if (and_mode) hit_fire = (|chan_en) & (&and_terms);
    else          hit_fire = |or_terms;
  end
endmodule

// File: rtl/trig_pulse_gen.sv
// Emits LEN high cycles starting in the cycle after start is sampled.
module trig_pulse_gen #(
  parameter int LEN = 8,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    if (start) cnt_d = CW'(LEN);
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse = (cnt_q != '0);
endmodule

// File: rtl/trig_combiner.sv
module trig_combiner #(
  parameter int N_CH         = 8,
  parameter int PULSE_CYCLES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] hit_in,
  input  logic            ext_trig,
  input  logic [N_CH-1:0] chan_en,
  input  logic            and_mode,
  input  logic            follower,
  input  logic            rearm,
  output logic            trig,
  output logic            trig_out,
  output logic [N_CH-1:0] hit_pattern
);
  import trig_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // Hits and external line share one synchronizer vector; the top bit is external.
  logic [N_CH:0] lvl, rise;
  trig_sync_edge #(.W(N_CH + 1)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .async_in ({ext_trig, hit_in}),
    .level    (lvl),
    .rise     (rise)
  );

  logic hit_fire;
  trig_coinc #(.N_CH(N_CH)) u_coinc (
    .edge_in  (rise[N_CH-1:0]),
    .chan_en  (chan_en),
    .and_mode (and_mode),
    .hit_fire (hit_fire)
  );

  trig_state_e     state_q, state_d;
  logic            fire;
  logic [N_CH-1:0] pat_q, pat_d;
  logic            pat_en;

  always_comb begin
    fire    = (state_q == ST_ARMED) && (hit_fire || (follower && rise[N_CH]));
    state_d = state_q;
    if (fire)                                state_d = ST_FIRED;
    else if (state_q == ST_FIRED && rearm)   state_d = ST_ARMED;
    pat_en  = fire;
    pat_d   = lvl[N_CH-1:0] & chan_en;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= ST_ARMED;
      pat_q   <= '0;
    end else begin
      state_q <= state_d;
      if (pat_en) pat_q <= pat_d;
    end
  end

  trig_pulse_gen #(.LEN(PULSE_CYCLES)) u_pulse (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .start (fire),
    .pulse (trig_out)
  );

  assign trig        = (state_q == ST_FIRED);
  assign hit_pattern = pat_q;
endmodule

// File: rtl/trig_combiner_chk.sv
module trig_combiner_chk #(
  parameter int N_CH         = 8,
  parameter int PULSE_CYCLES = 8,
  localparam int RW = $clog2(PULSE_CYCLES + 2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] chan_en,
  input logic            rearm,
  input logic            trig,
  input logic            trig_out,
  input logic [N_CH-1:0] hit_pattern
);
  logic [RW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (trig_out) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> $rose(trig));

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_out) |-> run_len == RW'(PULSE_CYCLES));

  // R6
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !rearm) |=> trig);

  // R5
  pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !rearm) |=> $stable(hit_pattern));

  // R3
  pattern_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> (hit_pattern & ~$past(chan_en)) == '0);
endmodule

bind trig_combiner trig_combiner_chk #(.N_CH(N_CH), .PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rearm(rearm),
  .trig(trig), .trig_out(trig_out), .hit_pattern(hit_pattern)
);

// File: tb/trig_combiner_test.sv
module trig_combiner_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] hit_in;
  logic       ext_trig;
  logic [7:0] chan_en;
  logic       and_mode;
  logic       follower;
  logic       rearm;
  logic       trig, trig_out;
  logic [7:0] hit_pattern;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  trig_combiner uut (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .ext_trig(ext_trig),
    .chan_en(chan_en), .and_mode(and_mode), .follower(follower), .rearm(rearm),
    .trig(trig), .trig_out(trig_out), .hit_pattern(hit_pattern)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Return hits low and re-arm.
  task automatic settle();
    hit_in = '0; ext_trig = 1'b0;
    cyc(4);
    rearm = 1'b1; cyc(1); rearm = 1'b0;
    cyc(2);
  endtask

  task automatic t_reset();
    chk("R1 trig after reset", trig, 0);
    chk("R1 trig_out after reset", trig_out, 0);
    chk("R1 pattern after reset", hit_pattern, 0);
  endtask

  task automatic t_or_fire();
    and_mode = 0; chan_en = 8'hFF;
    hit_in = 8'h24;
    cyc(2); chk("R2 not yet fired at 2 cycles", trig, 0);
    cyc(1); chk("R2 OR fire at 3 cycles", trig, 1);
    chk("R4 pulse starts with trig", trig_out, 1);
    chk("R5 pattern latched", hit_pattern, 8'h24);
    cyc(7); chk("R4 pulse high in 8th cycle", trig_out, 1);
    cyc(1); chk("R4 pulse low after 8 cycles", trig_out, 0);
  endtask

  task automatic t_ignore_and_rearm();
    hit_in = 8'h24 | 8'h01; cyc(5);
    chk("R6 trig held", trig, 1);
    chk("R6 no new pulse", trig_out, 0);
    chk("R6 pattern unchanged", hit_pattern, 8'h24);
    rearm = 1'b1; cyc(1); rearm = 1'b0;
    chk("R7 rearm clears trig", trig, 0);
    cyc(5);
    chk("R10 held level does not refire", trig, 0);
    settle();
  endtask

  task automatic t_mask();
    chan_en = 8'hF0; hit_in = 8'h0F; cyc(6);
    chk("R3 masked channels ignored", trig, 0);
    hit_in = 8'h8F; cyc(3);
    chk("R3 enabled channel fires", trig, 1);
    chk("R5 pattern omits masked", hit_pattern, 8'h80);
    settle();
  endtask

  task automatic t_and();
    and_mode = 1; chan_en = 8'h0F;
    hit_in = 8'h07; cyc(6);
    chk("R8 partial coincidence no fire", trig, 0);
    hit_in = 8'h00; cyc(4);
    hit_in = 8'h0F; cyc(3);
    chk("R8 full coincidence fires", trig, 1);
    chk("R8 pattern", hit_pattern, 8'h0F);
    settle();
    chan_en = 8'h00; hit_in = 8'hFF; cyc(6);
    chk("R8 all masked never fires", trig, 0);
    settle();
    and_mode = 0; chan_en = 8'hFF;
  endtask

  task automatic t_ext();
    follower = 0; ext_trig = 1'b1; cyc(6);
    chk("R9 head ignores ext", trig, 0);
    chk("R9 head no pulse", trig_out, 0);
    settle();
    follower = 1; ext_trig = 1'b1;
    cyc(2); chk("R9 ext not yet at 2 cycles", trig, 0);
    cyc(1); chk("R9 follower ext fires", trig, 1);
    chk("R9 ext pulse", trig_out, 1);
    chk("R5 ext pattern empty", hit_pattern, 0);
    settle();
    follower = 0;
  endtask

  initial begin
    rst_n = 1'b0; hit_in = '0; ext_trig = 0; chan_en = 8'hFF;
    and_mode = 0; follower = 0; rearm = 0;
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_or_fire();
    t_ignore_and_rearm();
    t_mask();
    t_and();
    t_ext();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule